// File: doc/BRIEF.md
# Two-Channel Card-Host DMA Engine

This block moves data between a memory-card host controller's data FIFOs and system memory. Software chooses one channel at a time through the mode register. Channel 0 fetches words from memory and pushes them into the outbound FIFO toward the card. Channel 1 pops words from the inbound FIFO and stores them to memory. Software also sets a buffer address, which must be 128-byte aligned, and writes the start bit. The transfer length comes from the card-side block-count input, at 512 bytes per block.

Each channel has its own active-low hold bit, its own completion flag and its own error flag. Both flag groups have mask registers, and one interrupt line combines every unmasked flag. Registers are 64-bit words on 0x8 spacing. Byte offsets: mode 0x00, control 0x08, channel hold 0x10, completion 0x18, completion mask 0x20, error 0x28, error mask 0x30, buffer address 0x38. On the memory side, a request is held until it is acknowledged. On the card side, FIFO ports are push/full and pop/empty, and the inbound head word is visible while the FIFO is not empty.

Top module: `cardhost_dma`

## Requirements
- R1: Mode bit 16 selects the channel. 0 selects channel 0, which reads memory and pushes each word to the outbound FIFO. 1 selects channel 1, which pops the inbound FIFO and writes each word to memory.
- R2: The mode register stores bit 16, the bus-width field at bits 5:4 and bit 0. It reads back exactly those bits, and every other bit reads 0.
- R3: With mode bit 0 set to 1, the memory address advances by 8 bytes after each beat. With bit 0 at 0, every beat uses the buffer address.
- R4: Writing control bit 0 as 1 starts a transfer only while the engine is idle. A start written during a transfer is ignored and changes neither its length nor its addresses.
- R5: A transfer moves block-count × 64 words of 64 bits, which is 512 bytes per block.
- R6: The completion register sets bit 16 for channel 0 or bit 17 for channel 1. For channel 0 it sets after the final FIFO push; for channel 1 it sets after the final memory acknowledge.
- R7: A start is rejected when the buffer address has any of bits 6:0 set, or when the block count is 0. A rejected start makes no memory or FIFO access and sets error bit 16 (channel 0) or bit 17 (channel 1) at offset 0x28.
- R8: Hold-register bit 8 (channel 0) and bit 9 (channel 1) reset to 1. Writing a 0 aborts that channel's transfer without setting its completion flag, and a start to a held channel is ignored.
- R9: Writing 0 to a completion or error bit clears it. Writing 1 leaves it unchanged.
- R10: The interrupt is the OR of all completion and error bits whose mask bit is 0. Both mask registers reset to all ones.
- R11: A memory request keeps its address and data until acknowledged. The engine never pushes into a full FIFO and never pops an empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| blk_cnt | input | 16 | Number of 512-byte blocks |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| tx_push | output | 1 | Push into the outbound FIFO |
| tx_data | output | 64 | Outbound FIFO data |
| tx_full | input | 1 | Outbound FIFO full |
| rx_pop | output | 1 | Pop from the inbound FIFO |
| rx_data | input | 64 | Inbound FIFO head word |
| rx_empty | input | 1 | Inbound FIFO empty |
| irq | output | 1 | Interrupt, unmasked flags ORed |

## Verification
A corrupted address register or address-mode latch shows up within one beat as a wrong mem_addr, and the memory model flags it at the acknowledge. A wrong beat counter shows at the completion flag: the word count seen at the moment bit 16 or 17 rises differs from block-count × 64. A lost abort or a wrongly accepted start keeps memory traffic running during a window in which the bench expects none, and that shows within a few hundred cycles. Bad flag or mask state shows on irq in the cycle after the register write.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  // register word index = byte offset / 8
  localparam logic [2:0] IDX_MODE  = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_CHRST = 3'd2;
  localparam logic [2:0] IDX_DONE  = 3'd3;
  localparam logic [2:0] IDX_DMSK  = 3'd4;
  localparam logic [2:0] IDX_ERR   = 3'd5;
  localparam logic [2:0] IDX_EMSK  = 3'd6;
  localparam logic [2:0] IDX_ADDR  = 3'd7;

  localparam int DIR_BIT   = 16;
  localparam int BWID_LO   = 4;
  localparam int INC_BIT   = 0;
  localparam int START_BIT = 0;
  localparam int RUN0_BIT  = 8;
  localparam int FLAG0_BIT = 16;
  localparam int NCH       = 2;
  localparam int MASK_W    = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_PUSH,
    ST_POP,
    ST_MWR
  } xfer_state_t;
endpackage

// File: rtl/cdma_rst_sync.sv
module cdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cdma_flag.sv
module cdma_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr,
  input  logic wbit,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (set)             q_d = 1'b1;
    else if (wr && !wbit) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q) else $error("flag set lost"); // R6
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_idx,
  input  logic [RW-1:0]       reg_wdata,
  output logic [RW-1:0]       reg_rdata,
  input  logic [NCH-1:0]      done_set,
  input  logic [NCH-1:0]      err_set,
  output logic                mode_dir,
  output logic                mode_inc,
  output logic [AW-1:0]       buf_addr,
  output logic [NCH-1:0]      chan_run,
  output logic                start,
  output logic                irq
);
  logic              dir_q, dir_d, inc_q, inc_d;
  logic [1:0]        bwid_q, bwid_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [NCH-1:0]    run_q, run_d;
  logic [MASK_W-1:0] dmsk_q, dmsk_d, emsk_q, emsk_d;
  logic [NCH-1:0]    done_q, err_q;
  logic              wr_mode, wr_chrst, wr_done, wr_dmsk, wr_err, wr_emsk, wr_addr;

  assign wr_mode  = reg_wr && (reg_idx == IDX_MODE);
  assign wr_chrst = reg_wr && (reg_idx == IDX_CHRST);
  assign wr_done  = reg_wr && (reg_idx == IDX_DONE);
  assign wr_dmsk  = reg_wr && (reg_idx == IDX_DMSK);
  assign wr_err   = reg_wr && (reg_idx == IDX_ERR);
  assign wr_emsk  = reg_wr && (reg_idx == IDX_EMSK);
  assign wr_addr  = reg_wr && (reg_idx == IDX_ADDR);
  assign start    = reg_wr && (reg_idx == IDX_CTRL) && reg_wdata[START_BIT];

  always_comb begin
    dir_d  = dir_q;
    inc_d  = inc_q;
    bwid_d = bwid_q;
    addr_d = addr_q;
    run_d  = run_q;
    dmsk_d = dmsk_q;
    emsk_d = emsk_q;
    if (wr_mode) begin
      dir_d  = reg_wdata[DIR_BIT];
      inc_d  = reg_wdata[INC_BIT];
      bwid_d = reg_wdata[BWID_LO+1:BWID_LO];
    end
    if (wr_chrst) run_d  = reg_wdata[RUN0_BIT+NCH-1:RUN0_BIT];
    if (wr_dmsk)  dmsk_d = reg_wdata[MASK_W-1:0];
    if (wr_emsk)  emsk_d = reg_wdata[MASK_W-1:0];
    if (wr_addr)  addr_d = reg_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      inc_q  <= 1'b0;
      bwid_q <= 2'b00;
      addr_q <= '0;
      run_q  <= '1;
      dmsk_q <= '1;
      emsk_q <= '1;
    end else begin
      dir_q  <= dir_d;
      inc_q  <= inc_d;
      bwid_q <= bwid_d;
      addr_q <= addr_d;
      run_q  <= run_d;
      dmsk_q <= dmsk_d;
      emsk_q <= emsk_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flags
    cdma_flag u_done (
      .clk(clk), .rst_n(rst_n), .set(done_set[c]), .wr(wr_done),
      .wbit(reg_wdata[FLAG0_BIT+c]), .q(done_q[c])
    );
    cdma_flag u_err (
      .clk(clk), .rst_n(rst_n), .set(err_set[c]), .wr(wr_err),
      .wbit(reg_wdata[FLAG0_BIT+c]), .q(err_q[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_MODE: begin
        reg_rdata[DIR_BIT]              = dir_q;
        reg_rdata[BWID_LO+1:BWID_LO]    = bwid_q;
        reg_rdata[INC_BIT]              = inc_q;
      end
      IDX_CHRST: reg_rdata[RUN0_BIT+NCH-1:RUN0_BIT]   = run_q;
      IDX_DONE:  reg_rdata[FLAG0_BIT+NCH-1:FLAG0_BIT] = done_q;
      IDX_DMSK:  reg_rdata[MASK_W-1:0]                = dmsk_q;
      IDX_ERR:   reg_rdata[FLAG0_BIT+NCH-1:FLAG0_BIT] = err_q;
      IDX_EMSK:  reg_rdata[MASK_W-1:0]                = emsk_q;
      IDX_ADDR:  reg_rdata[AW-1:0]                    = addr_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(done_q & ~dmsk_q[FLAG0_BIT+NCH-1:FLAG0_BIT]) |
               |(err_q  & ~emsk_q[FLAG0_BIT+NCH-1:FLAG0_BIT]);

  assign mode_dir = dir_q;
  assign mode_inc = inc_q;
  assign buf_addr = addr_q;
  assign chan_run = run_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done && !reg_wdata[FLAG0_BIT] && !done_set[0] |=> !done_q[0]) else $error("clear failed"); // R9
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&dmsk_q[FLAG0_BIT+NCH-1:FLAG0_BIT]) && (&emsk_q[FLAG0_BIT+NCH-1:FLAG0_BIT]) |-> !irq)
    else $error("irq while masked"); // R10
endmodule

// File: rtl/cdma_xfer.sv
module cdma_xfer
  import cdma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 64,
  parameter int BLK_W       = 16,
  parameter int BLK_BYTES   = 512,
  parameter int ALIGN_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_dir,
  input  logic             mode_inc,
  input  logic [AW-1:0]    buf_addr,
  input  logic [BLK_W-1:0] blk_cnt,
  input  logic [NCH-1:0]   chan_run,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             tx_push,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_full,
  output logic             rx_pop,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_empty,
  output logic [NCH-1:0]   done_set,
  output logic [NCH-1:0]   err_set
);
  localparam int WORD_BYTES    = DW / 8;
  localparam int BEATS_PER_BLK = BLK_BYTES / WORD_BYTES;
  localparam int BEAT_LSB      = $clog2(BEATS_PER_BLK);
  localparam int CNT_W         = BLK_W + BEAT_LSB;
  localparam int ALIGN_LSB     = $clog2(ALIGN_BYTES);

  xfer_state_t      state_q, state_d;
  logic             dir_q, dir_d, inc_q, inc_d;
  logic [AW-1:0]    addr_q, addr_d, next_addr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    hold_q, hold_d;
  logic             abort, last, bad_start;

  assign next_addr = inc_q ? addr_q + AW'(WORD_BYTES) : addr_q;
  assign last      = (cnt_q == CNT_W'(1));
  assign abort     = (state_q != ST_IDLE) && !chan_run[dir_q];
  assign bad_start = (buf_addr[ALIGN_LSB-1:0] != '0) || (blk_cnt == '0);

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    inc_d    = inc_q;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    tx_push  = 1'b0;
    rx_pop   = 1'b0;
    done_set = '0;
    err_set  = '0;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start && chan_run[mode_dir]) begin
            if (bad_start) begin
              err_set[mode_dir] = 1'b1;
            end else begin
              dir_d   = mode_dir;
              inc_d   = mode_inc;
              addr_d  = buf_addr;
              cnt_d   = CNT_W'(blk_cnt) << BEAT_LSB;
              state_d = mode_dir ? ST_POP : ST_MRD;
            end
          end
        end
        ST_MRD: begin
          mem_req = 1'b1;
          if (mem_ack) begin
            hold_d  = mem_rdata;
            state_d = ST_PUSH;
          end
        end
        ST_PUSH: begin
          tx_push = !tx_full;
          if (!tx_full) begin
            cnt_d  = cnt_q - CNT_W'(1);
            addr_d = next_addr;
            if (last) begin
              done_set[0] = 1'b1;
              state_d     = ST_IDLE;
            end else begin
              state_d = ST_MRD;
            end
          end
        end
        ST_POP: begin
          rx_pop = !rx_empty;
          if (!rx_empty) begin
            hold_d  = rx_data;
            state_d = ST_MWR;
          end
        end
        ST_MWR: begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
          if (mem_ack) begin
            cnt_d  = cnt_q - CNT_W'(1);
            addr_d = next_addr;
            if (last) begin
              done_set[1] = 1'b1;
              state_d     = ST_IDLE;
            end else begin
              state_d = ST_POP;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      inc_q   <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      inc_q   <= inc_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = hold_q;
  assign tx_data   = hold_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)) || abort)
    else $error("request dropped"); // R11
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full) else $error("push into full"); // R11
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty) else $error("pop from empty"); // R11
  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) && !inc_q |-> $stable(addr_q))
    else $error("fixed address moved"); // R3
  AST_ALIGNED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && ($past(state_q) == ST_IDLE) |-> (addr_q[ALIGN_LSB-1:0] == '0))
    else $error("unaligned start accepted"); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && !chan_run[dir_q] |=> (state_q == ST_IDLE))
    else $error("abort ignored"); // R8
  AST_HELD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && start && !chan_run[mode_dir] |=> (state_q == ST_IDLE))
    else $error("start to held channel"); // R8
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_set, err_set})) else $error("multiple flag events"); // R6
endmodule

// File: rtl/cardhost_dma.sv
module cardhost_dma
  import cdma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 64,
  parameter int BLK_W       = 16,
  parameter int BLK_BYTES   = 512,
  parameter int ALIGN_BYTES = 128,
  parameter int RAW         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  input  logic [BLK_W-1:0] blk_cnt,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  output logic             tx_push,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_full,
  output logic             rx_pop,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_empty,
  output logic             irq
);
  logic             rst_n_s;
  logic             start, mode_dir, mode_inc;
  logic [AW-1:0]    buf_addr;
  logic [NCH-1:0]   chan_run, done_set, err_set;
  logic             unused_addr_lsb;

  assign unused_addr_lsb = ^reg_addr[2:0];

  cdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cdma_regs #(.AW(AW), .RW(64)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_idx(reg_addr[5:3]),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_set(done_set), .err_set(err_set),
    .mode_dir(mode_dir), .mode_inc(mode_inc), .buf_addr(buf_addr),
    .chan_run(chan_run), .start(start), .irq(irq)
  );

  cdma_xfer #(
    .AW(AW), .DW(DW), .BLK_W(BLK_W), .BLK_BYTES(BLK_BYTES), .ALIGN_BYTES(ALIGN_BYTES)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n_s), .start(start), .mode_dir(mode_dir), .mode_inc(mode_inc),
    .buf_addr(buf_addr), .blk_cnt(blk_cnt), .chan_run(chan_run),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .done_set(done_set), .err_set(err_set)
  );
endmodule

// File: tb/sim_cardhost_dma.sv
module sim_cardhost_dma;
  localparam logic [5:0] A_MODE = 6'h00, A_CTRL = 6'h08, A_CHRST = 6'h10, A_DONE = 6'h18,
                         A_DMSK = 6'h20, A_ERR = 6'h28, A_EMSK = 6'h30, A_ADDR = 6'h38;
  localparam int BEATS = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_wr, mem_req, mem_we, mem_ack, tx_push, tx_full, rx_pop, rx_empty, irq;
  logic [5:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata, tx_data, rx_data;
  logic [15:0] blk_cnt;
  logic [31:0] mem_addr;

  cardhost_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .blk_cnt(blk_cnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .irq(irq)
  );

  int checks = 0, fails = 0;
  int mrd_n = 0, mwr_n = 0, push_n = 0, rx_idx = 0, bad = 0;
  logic [31:0] exp_base = 32'h0;
  bit exp_inc = 1'b0;
  bit done_flag = 1'b0;

  function automatic logic [63:0] mpat(input logic [31:0] a);
    return {~a, a};
  endfunction
  function automatic logic [63:0] rpat(input int i);
    return {32'hC0DE_0000 + i[31:0], ~i[31:0]};
  endfunction
  function automatic logic [31:0] exp_addr(input int k);
    return exp_inc ? exp_base + 32'(k * 8) : exp_base;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // memory and FIFO models, driven away from the active edge
  always @(negedge clk) begin
    tx_full  = ($urandom_range(0, 3) == 0);
    rx_empty = ($urandom_range(0, 3) == 0);
    rx_data  = rpat(rx_idx);
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && $urandom_range(0, 2) != 0) begin
      mem_ack = 1'b1;
      if (mem_addr != exp_addr(mrd_n + mwr_n)) bad++;
      if (mem_we) begin
        if (mem_wdata != rpat(mwr_n)) bad++;
        mwr_n++;
      end else begin
        mem_rdata = mpat(mem_addr);
        mrd_n++;
      end
    end
    #1;
    if (tx_push) begin
      if (tx_data != mpat(exp_addr(push_n))) bad++;
      push_n++;
    end
    if (rx_pop) rx_idx++;
  end

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #3;
    d = reg_rdata;
  endtask

  task automatic prep(input logic [31:0] base, input bit inc);
    @(negedge clk);
    #4;
    exp_base = base; exp_inc = inc;
    mrd_n = 0; mwr_n = 0; push_n = 0; rx_idx = 0; bad = 0;
  endtask

  task automatic start_xfer(input bit ch, input bit inc, input logic [31:0] base, input int nblk);
    prep(base, inc);
    blk_cnt = 16'(nblk);
    wr(A_ADDR, {32'h0, base});
    wr(A_MODE, (64'(ch) << 16) | 64'h30 | 64'(inc));
    wr(A_CTRL, 64'h1);
  endtask

  task automatic finish_xfer(input bit ch, input int nblk, input string rq);
    logic [63:0] v;
    bit seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd(A_DONE, v);
      if (v[16+ch]) begin seen = 1'b1; break; end
    end
    chk(seen, {rq, " completion flag"}, v, 64'(1) << (16 + ch));
    if (ch == 1'b0) begin
      chk(push_n == nblk * BEATS, {rq, " pushes at completion"}, 64'(push_n), 64'(nblk * BEATS));
      chk(mrd_n == nblk * BEATS, {rq, " memory reads"}, 64'(mrd_n), 64'(nblk * BEATS));
    end else begin
      chk(mwr_n == nblk * BEATS, {rq, " memory writes at completion"}, 64'(mwr_n), 64'(nblk * BEATS));
    end
    chk(bad == 0, {rq, " address/data mismatches"}, 64'(bad), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] v;
    int n0, n1;
    void'($urandom(32'd7331));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; blk_cnt = '0;
    mem_ack = 1'b0; mem_rdata = '0; tx_full = 1'b0; rx_empty = 1'b1; rx_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(A_MODE, v);  chk(v == 64'h0, "R2 mode reset", v, 64'h0);
    rd(A_CHRST, v); chk(v == 64'h300, "R8 hold reset value", v, 64'h300);
    rd(A_DMSK, v);  chk(v == 64'hFFFF_FFFF, "R10 done mask reset", v, 64'hFFFF_FFFF);
    rd(A_EMSK, v);  chk(v == 64'hFFFF_FFFF, "R10 error mask reset", v, 64'hFFFF_FFFF);
    rd(A_DONE, v);  chk(v == 64'h0, "R6 done reset", v, 64'h0);
    chk(irq == 1'b0, "R10 irq reset", 64'(irq), 64'h0);

    // mode field readback
    wr(A_MODE, '1);
    rd(A_MODE, v); chk(v == 64'h1_0031, "R2 mode readback", v, 64'h1_0031);
    wr(A_MODE, 64'h0);

    // channel 0 incrementing, channel 1 fixed
    start_xfer(1'b0, 1'b1, 32'h1000_0000, 1);
    finish_xfer(1'b0, 1, "R1 R3 R5 R6 ch0 incr");
    start_xfer(1'b1, 1'b0, 32'h1000_4000, 2);
    finish_xfer(1'b1, 2, "R1 R3 R5 R6 R11 ch1 fixed");
    rd(A_DONE, v); chk(v == 64'h3_0000, "R6 both completion bits", v, 64'h3_0000);
    rd(A_ERR, v);  chk(v == 64'h0, "R6 no error after good runs", v, 64'h0);

    // interrupt masking
    chk(irq == 1'b0, "R10 irq masked", 64'(irq), 64'h0);
    wr(A_DMSK, 64'hFFFD_FFFF); #3;
    chk(irq == 1'b1, "R10 irq bit17 unmasked", 64'(irq), 64'h1);
    wr(A_DMSK, 64'hFFFF_FFFF); #3;
    chk(irq == 1'b0, "R10 irq remasked", 64'(irq), 64'h0);

    // write-zero clear
    wr(A_DONE, 64'h2_0000);
    rd(A_DONE, v); chk(v == 64'h2_0000, "R9 clear bit16 keep bit17", v, 64'h2_0000);
    wr(A_DMSK, 64'hFFFD_FFFF);
    wr(A_DONE, 64'h0); #3;
    chk(irq == 1'b0, "R9 R10 irq after clear", 64'(irq), 64'h0);
    rd(A_DONE, v); chk(v == 64'h0, "R9 all cleared", v, 64'h0);
    wr(A_DMSK, 64'hFFFF_FFFF);

    // rejected starts
    start_xfer(1'b0, 1'b1, 32'h2000_0040, 1);
    repeat (200) @(negedge clk);
    chk(mrd_n + mwr_n + push_n == 0, "R7 unaligned no traffic", 64'(mrd_n + push_n), 64'h0);
    rd(A_ERR, v);  chk(v == 64'h1_0000, "R7 unaligned error ch0", v, 64'h1_0000);
    rd(A_DONE, v); chk(v == 64'h0, "R7 no completion", v, 64'h0);
    wr(A_EMSK, 64'hFFFE_FFFF); #3;
    chk(irq == 1'b1, "R10 error irq", 64'(irq), 64'h1);
    wr(A_ERR, 64'h0);
    wr(A_EMSK, 64'hFFFF_FFFF);
    start_xfer(1'b1, 1'b1, 32'h2000_0000, 0);
    repeat (200) @(negedge clk);
    chk(rx_idx + mwr_n == 0, "R7 zero count no traffic", 64'(rx_idx + mwr_n), 64'h0);
    rd(A_ERR, v);  chk(v == 64'h2_0000, "R7 zero count error ch1", v, 64'h2_0000);
    wr(A_ERR, 64'h0);

    // abort and held channel
    start_xfer(1'b1, 1'b1, 32'h3000_0000, 4);
    repeat (100) @(negedge clk);
    wr(A_CHRST, 64'h100);
    repeat (3) @(negedge clk);
    n1 = mwr_n; n0 = rx_idx;
    repeat (300) @(negedge clk);
    chk(mwr_n == n1 && rx_idx == n0, "R8 abort stops traffic", 64'(mwr_n), 64'(n1));
    chk(n1 > 0 && n1 < 4 * BEATS, "R8 abort mid transfer", 64'(n1), 64'(4 * BEATS));
    rd(A_DONE, v); chk(v == 64'h0, "R8 no completion after abort", v, 64'h0);
    rd(A_CHRST, v); chk(v == 64'h100, "R8 hold readback", v, 64'h100);
    wr(A_CTRL, 64'h1);
    repeat (200) @(negedge clk);
    chk(mwr_n == n1 && rx_idx == n0, "R8 held start ignored", 64'(mwr_n), 64'(n1));
    wr(A_CHRST, 64'h300);
    start_xfer(1'b1, 1'b1, 32'h3000_8000, 1);
    finish_xfer(1'b1, 1, "R8 recovery after release");
    wr(A_DONE, 64'h0);

    // start while busy
    start_xfer(1'b0, 1'b1, 32'h4000_0000, 1);
    repeat (20) @(negedge clk);
    blk_cnt = 16'd3;
    wr(A_ADDR, 64'h5000_0000);
    wr(A_CTRL, 64'h1);
    finish_xfer(1'b0, 1, "R4 start while busy ignored");
    repeat (50) @(negedge clk);
    chk(push_n == BEATS, "R4 no restart after completion", 64'(push_n), 64'(BEATS));
    wr(A_DONE, 64'h0);

    // random transfers
    for (int t = 0; t < 6; t++) begin
      bit ch, inc;
      int nb;
      logic [31:0] base;
      ch   = 1'($urandom_range(0, 1));
      inc  = 1'($urandom_range(0, 1));
      nb   = $urandom_range(1, 3);
      base = 32'h6000_0000 | (32'($urandom_range(0, 4095)) << 7);
      start_xfer(ch, inc, base, nb);
      finish_xfer(ch, nb, "R1 R3 R5 random");
      wr(A_DONE, 64'h0);
    end

    summary();
  end
endmodule